// File: doc/BRIEF.md
# Masked-write clock divider control

This block holds one 32-bit divider control register and drives two independent integer clock dividers from it. Each write carries its own per-bit write-enable. The upper half of the write word chooses which lower-half bits change, and the lower half supplies their new values. Software can therefore set, clear, or clear-and-set one channel's fields without first reading the register back.

Each channel has a 5-bit divide field and a source-select bit. The select bit picks one of two source tick qualifiers, `src_tick[0]` or `src_tick[1]`, which run in the `clk` domain. The channel counts ticks of its selected source. On the last tick of each divided period it emits a clock-enable pulse that lasts exactly one cycle. A new divide value is taken up only when the running count wraps, so a period is never cut short.

Top module: `clkdiv_maskreg`

## Requirements
- R1: A write to address 0 changes stored bit i (0..15) to `reg_wdata[i]` only when `reg_wdata[16+i]` is 1. Every bit whose enable is 0 keeps its previous value. The new value is visible from the cycle after the write.
- R2: With `reg_addr` = 0, `reg_rdata` returns the stored 16-bit value in bits [15:0] and zero in bits [31:16]. At any other address, reads return zero and writes change nothing.
- R3: After reset the stored value is 0, so both channels divide by 1 and select source 0.
- R4: Channel 0 takes its divide field from stored bits [4:0] and its source select from stored bit 7, which is also driven on `src_sel[0]`.
- R5: Channel 1 takes its divide field from stored bits [12:8] and its source select from stored bit 15, which is also driven on `src_sel[1]`.
- R6: With active field value F, a channel pulses `div_pulse` once every F+1 ticks of its selected source.
- R7: A changed divide field takes effect only at the tick on which the current count wraps. The period in progress keeps the old length.
- R8: `div_pulse` is high only in a cycle in which the channel's selected source tick is high, and then for that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address; only 0 is decoded |
| reg_wdata | input | 32 | [31:16] bit enables, [15:0] new values |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data |
| src_tick | input | 2 | Tick qualifiers of the two selectable sources |
| src_sel | output | 2 | Source select of each channel |
| div_pulse | output | 2 | One-cycle clock enable per divided period |

## Verification
Random write words are mixed with random source ticks, including writes to an undecoded address. This separates correct masking from a plain overwrite and shows that stray addresses have no effect. Directed runs hold both ticks high and measure the distance between pulses. One run rewrites the ratio in the middle of a period, which separates a reload at the wrap from an immediate reload: the first distance must keep the old length and the next must take the new one. Random tick gaps paired with source switching show that the counter advances only on the selected source.

// File: rtl/clkdiv_maskreg.sv
module clkdiv_maskreg #(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_wr,
  output logic [31:0]       reg_rdata,
  input  logic [1:0]        src_tick,
  output logic [1:0]        src_sel,
  output logic [1:0]        div_pulse
);
  localparam int HALF    = 16;
  localparam int STRIDE  = 8;
  localparam int SEL_POS = 7;

  logic [HALF-1:0] ctrl;
  logic            hit;

  assign hit       = (reg_addr == '0);
  assign reg_rdata = hit ? {{HALF{1'b0}}, ctrl} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl <= '0;
    else if (reg_wr && hit)
      ctrl <= (ctrl & ~reg_wdata[31:HALF]) | (reg_wdata[HALF-1:0] & reg_wdata[31:HALF]);
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [DIV_W-1:0] cnt, lim;
    logic             sel, tick, wrap;

    assign sel  = ctrl[ch*STRIDE+SEL_POS];
    assign tick = sel ? src_tick[1] : src_tick[0];
    assign wrap = (cnt == lim);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        lim <= '0;
      end else if (tick) begin
        if (wrap) begin
          cnt <= '0;
          lim <= ctrl[ch*STRIDE +: DIV_W];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign src_sel[ch]   = sel;
    assign div_pulse[ch] = tick & wrap;
  end
endmodule

// File: rtl/clkdiv_maskreg_chk.sv
module clkdiv_maskreg_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              reg_wr,
  input logic [31:0]       reg_rdata,
  input logic [1:0]        src_tick,
  input logic [1:0]        src_sel,
  input logic [1:0]        div_pulse
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:16] == 16'h0); // R2

  AST_SEL0_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && !reg_wdata[23]) |=> (src_sel[0] == $past(src_sel[0]))); // R1

  AST_SEL1_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && !reg_wdata[31]) |=> (src_sel[1] == $past(src_sel[1]))); // R1

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == '0) |=> $stable(src_sel)); // R2

  AST_SEL0_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && reg_wdata[23] && reg_wdata[7]) |=> src_sel[0]); // R4

  AST_SEL1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && reg_wdata[31] && !reg_wdata[15]) |=> !src_sel[1]); // R5

  AST_PULSE0_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse[0] |-> (src_sel[0] ? src_tick[1] : src_tick[0])); // R8

  AST_PULSE1_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse[1] |-> (src_sel[1] ? src_tick[1] : src_tick[0])); // R8
endmodule

bind clkdiv_maskreg clkdiv_maskreg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_wr(reg_wr), .reg_rdata(reg_rdata), .src_tick(src_tick),
  .src_sel(src_sel), .div_pulse(div_pulse)
);

// File: tb/clkdiv_maskreg_bench.sv
module clkdiv_maskreg_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 0;
  logic [31:0] reg_rdata;
  logic [1:0]  src_tick = '0;
  logic [1:0]  src_sel;
  logic [1:0]  div_pulse;

  int checks = 0, errors = 0;
  logic [15:0] m_ctrl;
  logic [4:0]  m_cnt [2];
  logic [4:0]  m_lim [2];
  logic        last_pulse0;

  always #10 clk = ~clk;

  clkdiv_maskreg u_clkdiv_maskreg (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .src_tick(src_tick),
    .src_sel(src_sel), .div_pulse(div_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] masked(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic sel_tick(input int ch);
    return m_ctrl[ch*8+7] ? src_tick[1] : src_tick[0];
  endfunction

  task automatic model_reset();
    m_ctrl = '0;
    for (int c = 0; c < 2; c++) begin m_cnt[c] = '0; m_lim[c] = '0; end
  endtask

  // drive inputs at the falling edge, compare, then advance the model across the rising edge
  task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] w, input logic [1:0] t);
    logic [15:0] n_ctrl;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = w; src_tick = t;
    #1;
    check("R6/R8 pulse ch0", {31'b0, div_pulse[0]}, {31'b0, sel_tick(0) && m_cnt[0] == m_lim[0]});
    check("R6/R8 pulse ch1", {31'b0, div_pulse[1]}, {31'b0, sel_tick(1) && m_cnt[1] == m_lim[1]});
    check("R4/R5 src_sel", {30'b0, src_sel}, {30'b0, m_ctrl[15], m_ctrl[7]});
    check("R1/R2 rdata", reg_rdata, (a == 0) ? {16'h0, m_ctrl} : 32'h0);
    last_pulse0 = div_pulse[0];
    n_ctrl = (wr && a == 0) ? masked(m_ctrl, w) : m_ctrl;
    for (int c = 0; c < 2; c++) begin
      if (sel_tick(c)) begin
        if (m_cnt[c] == m_lim[c]) begin
          m_cnt[c] = '0;
          m_lim[c] = m_ctrl[c*8 +: 5];
        end else m_cnt[c] = m_cnt[c] + 1'b1;
      end
    end
    m_ctrl = n_ctrl;
  endtask

  task automatic run_until_pulse(output int n);
    n = 0;
    do begin
      step(0, 0, 0, 2'b11);
      n++;
    end while (!last_pulse0 && n < 100);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R3 reset rdata", reg_rdata, 32'h0);
    check("R3 reset src_sel", {30'b0, src_sel}, 32'h0);
    // divide by 1 after reset: a pulse on every tick
    for (int i = 0; i < 4; i++) step(0, 0, 0, 2'b11);
    check("R3 divide-by-1 pulse", {31'b0, last_pulse0}, 32'h1);

    // R1 set, clear and combined clear-and-set
    step(1, 0, 32'hFFFF_A5C3, 2'b00);
    step(1, 0, 32'h0081_0000, 2'b00);
    step(1, 0, 32'h0F00_0300, 2'b00);
    step(0, 0, 0, 2'b00);
    check("R1 masked result", reg_rdata, {16'h0, masked(masked(16'hA5C3, 32'h0081_0000), 32'h0F00_0300)});
    step(1, 1, 32'hFFFF_FFFF, 2'b00);
    step(0, 0, 0, 2'b00);
    check("R2 other address ignored", reg_rdata, {16'h0, masked(masked(16'hA5C3, 32'h0081_0000), 32'h0F00_0300)});

    // R6/R7 directed ratio change on channel 0 (source 0, ratio 4 then 2)
    step(1, 0, 32'hFFFF_0003, 2'b11);
    run_until_pulse(g);
    run_until_pulse(g);
    run_until_pulse(g);
    check("R6 period of field 3", g, 4);
    step(1, 0, 32'h001F_0001, 2'b11);
    run_until_pulse(g);
    check("R7 old period kept", g + 1, 4);
    run_until_pulse(g);
    check("R7 new period at wrap", g, 2);

    // R5 channel 1 field and select
    step(1, 0, 32'h9F00_8200, 2'b10);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 2'b10);
    check("R5 ch1 select", {31'b0, src_sel[1]}, 32'h1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [3:0] a;
      wr = ($urandom % 6) == 0;
      a  = (($urandom % 5) == 0) ? 4'd1 : 4'd0;
      step(wr, a, $urandom, 2'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule